// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is a target device on a two-wire I2C bus. It answers reads from an internal byte array of 2^ADDR_W locations. The design runs on a system clock and samples SCL and SDA through two-flop synchronisers. It detects START, repeated START and STOP from SDA edges while SCL is high, shifts in the control byte, and drives SDA through an open-drain enable, pulling the line low only when the enable is 1.

An address pointer is kept between transactions, so a read that carries no address returns the byte after the one last touched. To read from an arbitrary location, the master opens a write-mode transfer and sends one or two address bytes, as set by ADDR_BYTES. It then cuts that transfer short with a repeated START and issues a read. The write-mode transfer loads the pointer but stores nothing.

The array contents come from a fill function, so the block acts as a read-only memory. The master ends a read with a NACK and a STOP. A master ACK after a byte makes the target send the next location.

Top module: `i2c_rom_target`

## Requirements
- R1: START and STOP are recognised from synchronised SDA falling or rising while synchronised SCL is high. A START at any point, including mid-byte, restarts control-byte reception. A STOP at any point returns the target to idle. Neither one alters the address pointer unless a full address byte has completed.
- R2: Control bits 7..1, received MSB first, are compared with DEV_ADDR. On a match the target pulls SDA low for the ninth clock. On a mismatch it leaves SDA released, does not acknowledge, and sends nothing until the next START.
- R3: When control bit 0 (R/W) is 1, the target acknowledges and then shifts out the byte at the pointer, MSB first.
- R4: When R/W is 0, the target acknowledges ADDR_BYTES address bytes, high-order byte first. After the last one it loads the pointer with the low ADDR_W bits of the assembled address.
- R5: In a write-mode transfer, bytes that follow the address are not acknowledged and are not stored. A repeated START followed by a read returns the byte at the loaded address.
- R6: The pointer advances by one after each transmitted data byte and wraps from 2^ADDR_W-1 to 0. It keeps its value across transactions, so back-to-back current-address reads return successive locations.
- R7: A master ACK (SDA low) after a data byte makes the target send the next location. A NACK makes it release SDA and wait for START or STOP.
- R8: The SDA drive enable is 0 out of reset and whenever the target is idle. It changes only while synchronised SCL is low.
- R9: The byte stored at array address a equals (29*a + FILL_SEED) mod 256. With the defaults FILL_SEED is 0x5A and DEV_ADDR is 0x50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bound checker watches four properties on every cycle. SDA drive moves only while SCL is low. The pointer moves only on an address load or a completed data byte, steps by exactly one and wraps at the top. START and STOP force control reception or idle, and the target never drives SDA while idle. What the bus actually carries can only be shown by the bench's scenarios: matching data for random, current-address and sequential reads, a missing acknowledge for a foreign device field or for write data, and a pointer left unchanged after START or STOP in mid-byte.

// File: rtl/i2c_rom_pkg.sv
package i2c_rom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_CTRL,
    ST_RX_ADDR,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_e;

  // What follows the acknowledge clock the target is driving
  typedef enum logic [1:0] {
    NXT_READ,
    NXT_ADDR,
    NXT_DONE
  } ack_next_e;

  // Array contents: (29*a + seed) mod 256
  function automatic logic [7:0] fill_byte(input int unsigned a, input logic [7:0] seed);
    return 8'(a * 32'd29 + {24'd0, seed});
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  // Idle bus is high, so every stage resets to 1 to avoid false edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;

endmodule

// File: rtl/i2c_rom_array.sv
module i2c_rom_array
  import i2c_rom_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] FILL_SEED = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = fill_byte(g, FILL_SEED);
  end

  assign data = mem[addr];

endmodule

// File: rtl/i2c_rom_target.sv
module i2c_rom_target
  import i2c_rom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         ADDR_BYTES = 1,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] FILL_SEED  = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int ADDR_BITS = 8 * ADDR_BYTES;
  localparam logic [1:0] LAST_ABYTE = 2'(ADDR_BYTES - 1);

  function automatic logic [ADDR_W-1:0] ptr_after(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  // Bus events
  logic scl_s, sda_s, ev_start, ev_stop, ev_rise, ev_fall;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  // State
  tgt_state_e             state;
  ack_next_e              ack_nxt;
  logic [3:0]             bit_cnt;
  logic [7:0]             rx_sh, tx_sh;
  logic [ADDR_W-1:0]      ptr;
  logic [ADDR_BITS-1:0]   addr_acc, addr_next;
  logic [1:0]             abyte_cnt;
  logic [7:0]             rom_q;

  i2c_rom_array #(.ADDR_W(ADDR_W), .FILL_SEED(FILL_SEED)) u_rom (
    .addr(ptr),
    .data(rom_q)
  );

  // Named internal events
  logic rx_active, rx_shift, byte_rx_done, ctrl_hit, addr_last;
  logic ptr_load, byte_sent, in_idle, ctrl_fresh;

  assign rx_active    = (state == ST_RX_CTRL) || (state == ST_RX_ADDR);
  assign rx_shift     = rx_active && ev_rise && (bit_cnt != 4'd8);
  assign byte_rx_done = rx_active && ev_fall && (bit_cnt == 4'd8);
  assign ctrl_hit     = (rx_sh[7:1] == DEV_ADDR);
  assign addr_last    = (abyte_cnt == LAST_ABYTE);
  assign addr_next    = ADDR_BITS'({addr_acc, rx_sh});
  assign ptr_load     = byte_rx_done && (state == ST_RX_ADDR) && addr_last;
  assign byte_sent    = (state == ST_TX) && ev_fall && (bit_cnt == 4'd7);
  assign in_idle      = (state == ST_IDLE);
  assign ctrl_fresh   = (state == ST_RX_CTRL) && (bit_cnt == 4'd0);

  // Control sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_nxt   <= NXT_DONE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      addr_acc  <= '0;
      abyte_cnt <= '0;
    end else if (ev_start) begin
      state     <= ST_RX_CTRL;
      bit_cnt   <= '0;
      abyte_cnt <= '0;
    end else if (ev_stop) begin
      state     <= ST_IDLE;
    end else begin
      if (rx_shift) begin
        rx_sh   <= {rx_sh[6:0], sda_s};
        bit_cnt <= bit_cnt + 4'd1;
      end
      unique case (state)
        ST_RX_CTRL: begin
          if (byte_rx_done) begin
            bit_cnt <= '0;
            if (ctrl_hit) begin
              state   <= ST_ACK;
              ack_nxt <= rx_sh[0] ? NXT_READ : NXT_ADDR;
            end else begin
              state   <= ST_IDLE;
            end
          end
        end
        ST_RX_ADDR: begin
          if (byte_rx_done) begin
            bit_cnt  <= '0;
            addr_acc <= addr_next;
            state    <= ST_ACK;
            if (addr_last) begin
              ack_nxt <= NXT_DONE;
            end else begin
              ack_nxt   <= NXT_ADDR;
              abyte_cnt <= abyte_cnt + 2'd1;
            end
          end
        end
        ST_ACK: begin
          if (ev_fall) begin
            bit_cnt <= '0;
            unique case (ack_nxt)
              NXT_READ: begin
                tx_sh <= rom_q;
                state <= ST_TX;
              end
              NXT_ADDR: state <= ST_RX_ADDR;
              default:  state <= ST_IDLE;
            endcase
          end
        end
        ST_TX: begin
          if (ev_fall) begin
            if (bit_cnt == 4'd7) begin
              state <= ST_MACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (ev_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (ev_fall) begin
            tx_sh   <= rom_q;
            bit_cnt <= '0;
            state   <= ST_TX;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Address pointer: changes only at byte boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= ADDR_W'(addr_next);
    end else if (byte_sent) begin
      ptr <= ptr_after(ptr);
    end
  end

  assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !tx_sh[7]);

endmodule

// File: rtl/i2c_rom_target_chk.sv
module i2c_rom_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              byte_sent,
  input logic              ptr_load,
  input logic [ADDR_W-1:0] ptr,
  input logic              in_idle,
  input logic              ctrl_fresh
);

  a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r1_ptr_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(byte_sent || ptr_load));

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_sent && (ptr != '1)) |=> (ptr == $past(ptr) + 1'b1));

  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_sent && (ptr == '1)) |=> (ptr == '0));

  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> ctrl_fresh);

  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> in_idle);

endmodule

bind i2c_rom_target i2c_rom_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .sda_oe    (sda_oe),
  .ev_start  (ev_start),
  .ev_stop   (ev_stop),
  .byte_sent (byte_sent),
  .ptr_load  (ptr_load),
  .ptr       (ptr),
  .in_idle   (in_idle),
  .ctrl_fresh(ctrl_fresh)
);

// File: tb/i2c_rom_target_tb.sv
module i2c_rom_target_tb;

  localparam logic [6:0] DEV = 7'h50;
  localparam int         WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_vec = 0;
  int n_miss = 0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_rom_target u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl),
    .sda_i (sda_line),
    .sda_oe(sda_oe)
  );

  // Expected array byte, R9: (29*a + 0x5A) mod 256
  function automatic logic [7:0] exp_byte(input int a);
    return 8'((((a % 256) * 29) + 90) % 256);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic q;
    repeat (10) @(negedge clk);
  endtask

  // Bus primitives
  task automatic bus_start;
    sda_m = 1'b1; q; scl = 1'b1; q; sda_m = 1'b0; q; scl = 1'b0; q;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; q; scl = 1'b1; q; sda_m = 1'b1; q;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q; scl = 1'b1; q; q; scl = 1'b0; q;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q; scl = 1'b1; q; b = sda_line; q; scl = 1'b0; q;
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack_bit);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack_bit);
  endtask

  task automatic get_byte(output logic [7:0] d, input logic m_ack);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = {d[6:0], b};
    end
    put_bit(!m_ack);
  endtask

  // Scenarios
  task automatic t_reset;
    check("R8", "sda_oe after reset", int'(sda_oe), 0);
  endtask

  task automatic t_random_read(input int addr);
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a); check("R2", "ack of write control", int'(a), 0);
    put_byte(8'(addr), a);    check("R4", "ack of address byte", int'(a), 0);
    bus_start;
    put_byte({DEV, 1'b1}, a); check("R3", "ack of read control", int'(a), 0);
    get_byte(d, 1'b0);
    bus_stop;
    check("R5", "random read data (R9 fill)", int'(d), int'(exp_byte(addr)));
  endtask

  task automatic t_current_read(input int exp_addr);
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b1}, a); check("R3", "ack of current read control", int'(a), 0);
    get_byte(d, 1'b0);
    bus_stop;
    check("R6", "current read data", int'(d), int'(exp_byte(exp_addr)));
  endtask

  task automatic t_foreign_device;
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV ^ 7'h01, 1'b1}, a); check("R2", "no ack for foreign device", int'(a), 1);
    get_byte(d, 1'b0);
    check("R2", "bus stays released after mismatch", int'(d), 8'hFF);
    bus_stop;
  endtask

  task automatic t_sequential(input int addr);
    logic a, b; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a); put_byte(8'(addr), a);
    bus_start;
    put_byte({DEV, 1'b1}, a);
    for (int k = 0; k < 3; k++) begin
      get_byte(d, k < 2);
      check("R7", "sequential byte", int'(d), int'(exp_byte(addr + k)));
    end
    get_bit(b);
    check("R7", "SDA released after NACK", int'(b), 1);
    bus_stop;
  endtask

  task automatic t_abort_stop;
    logic a;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop;
  endtask

  task automatic t_abort_start(input int exp_addr);
    logic a; logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b0}, a);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_start;
    put_byte({DEV, 1'b1}, a); check("R1", "ack after mid-byte START", int'(a), 0);
    get_byte(d, 1'b0);
    bus_stop;
    check("R1", "pointer kept after mid-byte START", int'(d), int'(exp_byte(exp_addr)));
  endtask

  task automatic t_write_data(input int addr);
    logic a;
    bus_start;
    put_byte({DEV, 1'b0}, a); put_byte(8'(addr), a);
    check("R4", "address ack before data", int'(a), 0);
    put_byte(8'hC3, a);
    check("R5", "write data not acknowledged", int'(a), 1);
    bus_stop;
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_random_read(8'h10);
    t_current_read(8'h11);
    t_current_read(8'h12);
    t_current_read(8'h13);
    t_foreign_device;
    t_current_read(8'h14);
    t_sequential(8'h20);
    t_current_read(8'h23);
    t_abort_stop;          // R1: STOP in mid-byte keeps pointer at 0x24
    t_current_read(8'h24);
    t_abort_start(8'h25);
    t_write_data(8'h40);   // R5: 0xC3 is not stored
    t_current_read(8'h40);
    t_random_read(8'hFF);
    t_current_read(8'h00); // R6 wrap
    check("R8", "sda_oe idle at end", int'(sda_oe), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule